// File: doc/BRIEF.md
# Near-End Loopback Entry/Exit Sequencer

This block sits on the controller side of a parallel PHY interface. It moves the PHY into near-end loopback, where the PHY returns transmitted data on the parallel side, and later moves it back to normal operation. It drives the PHY power-down state and the PHY reset. It writes the PHY loopback control register over a simple address/data message bus and waits for the PHY to write its loopback status back. It then tells the link-training logic which mode is ready to train in.

Two exit paths are available. A handshake exit writes the control register with the enable bit clear and waits for the status reply. A reset exit holds the PHY in reset for a fixed count and clears the latched control state. The reset exit is taken on request. It is also taken on its own when the PHY rejects the handshake exit with its error bit, or when a reply does not arrive within the programmed timeout.

Top module: `lbk_seq`

## Requirements
- R1: While rst_ni is low and afterwards, phy_rst_no stays low for exactly 16 sampled cycles after rst_ni rises. During that time pd_o is 2'b10 (transmitter and receiver off, clock running) and lb_ready_o, norm_ready_o, msg_valid_o and err_o are 0. Then norm_ready_o becomes 1 with pd_o = 2'b00.
- R2: When lb_req_i is seen high in normal mode, pd_o becomes 2'b10 and phy_rst_no goes low for 16 cycles. In the first cycle after release, the block issues a single-cycle write to address CTRL_ADDR with data bit 0 (enable) = 1 and bits 2:1 = the cfg_pos_i value sampled when entry began.
- R3: lb_ready_o rises only in the cycle after a status write: msg_valid_i high, msg_addr_i = STAT_ADDR, data bit 0 = 1 and bit 1 = 0. Writes to any other address have no effect.
- R4: With exit_rst_i low, dropping lb_req_i in loopback issues a single write to CTRL_ADDR with bit 0 = 0 and bits 2:1 unchanged. A status write with bit 0 = 0 and bit 1 = 0 then gives norm_ready_o = 1 and pd_o = 2'b00 in the next cycle, with no PHY reset.
- R5: A status write with bit 1 (error) = 1 during the handshake exit causes a reset exit: phy_rst_no is low for 16 cycles, then norm_ready_o = 1.
- R6: With exit_rst_i high when lb_req_i drops in loopback, the block issues no message. It goes straight into a 16-cycle PHY reset and then normal mode.
- R7: If cfg_timeout_i is nonzero and no matching reply arrives within cfg_timeout_i cycles of a wait, err_o goes to 1 and the reset exit starts. err_o stays 1 until rst_ni. A cfg_timeout_i of 0 waits without limit.
- R8: lb_ready_o and norm_ready_o are never high together.
- R9: msg_valid_o is high only while pd_o = 2'b10 and phy_rst_no = 1.
- R10: A status write with bit 1 = 1 during entry aborts through the 16-cycle reset exit to normal mode and leaves err_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lb_req_i | input | 1 | 1 requests loopback, 0 requests normal mode |
| exit_rst_i | input | 1 | Selects reset exit instead of handshake exit |
| cfg_pos_i | input | 2 | Requested loopback position |
| cfg_timeout_i | input | TO_W | Reply wait limit in cycles, 0 = none |
| pd_o | output | 2 | PHY power-down state |
| phy_rst_no | output | 1 | Active-low PHY reset |
| msg_valid_o | output | 1 | Outgoing register-write strobe |
| msg_addr_o | output | ADDR_W | Outgoing register address |
| msg_data_o | output | DATA_W | Outgoing register data |
| msg_valid_i | input | 1 | Incoming register-write strobe from PHY |
| msg_addr_i | input | ADDR_W | Incoming register address |
| msg_data_i | input | DATA_W | Incoming register data |
| lb_ready_o | output | 1 | Loopback mode ready for training |
| norm_ready_o | output | 1 | Normal mode ready for training |
| err_o | output | 1 | Sticky handshake timeout flag |

## Verification
The in-line assertions check several properties on every cycle. The two ready flags are never high together. Messages go out only with the PHY powered down and out of reset. Every release of the PHY reset follows exactly 16 low cycles. Loopback readiness and handshake-exit readiness only follow the matching status write, and the error flag never clears. The bench scenarios cover the rest: the latched position and enable bit in each control write, choosing an exit path from exit_rst_i and from the PHY's error bit, the exact timeout length, the unlimited wait when the timeout is zero, and ignoring writes to the wrong address.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;
  localparam int POS_W   = 2;
  localparam int PD_W    = 2;
  localparam int EN_BIT  = 0;
  localparam int ERR_BIT = 1;
  localparam int POS_LSB = 1;
  localparam logic [PD_W-1:0] PD_ACTIVE = 2'b00;
  localparam logic [PD_W-1:0] PD_OFF    = 2'b10;

  typedef enum logic [2:0] {
    ST_HOLD, ST_NORM, ST_EHOLD, ST_SEND_EN,
    ST_WAIT_EN, ST_LOOP, ST_SEND_DIS, ST_WAIT_DIS
  } lbk_state_e;
endpackage

// File: rtl/lbk_hold_cnt.sv
`timescale 1ns/1ps
module lbk_hold_cnt #(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int W = $clog2(N + 1);
  logic [W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == W'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lbk_wait_timer.sv
`timescale 1ns/1ps
module lbk_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // limit of zero disables expiry
  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lbk_stat_dec.sv
`timescale 1ns/1ps
module lbk_stat_dec
  import lbk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_en_o,
  output logic              ack_dis_o,
  output logic              perr_o
);
  logic hit;
  assign hit       = valid_i && (addr_i == STAT_ADDR);
  assign perr_o    = hit && data_i[ERR_BIT];
  assign ack_en_o  = hit && !data_i[ERR_BIT] &&  data_i[EN_BIT];
  assign ack_dis_o = hit && !data_i[ERR_BIT] && !data_i[EN_BIT];
endmodule

// File: rtl/lbk_seq.sv
`timescale 1ns/1ps
module lbk_seq
  import lbk_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int TO_W    = 8,
  parameter int RST_CYC = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h020,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lb_req_i,
  input  logic              exit_rst_i,
  input  logic [POS_W-1:0]  cfg_pos_i,
  input  logic [TO_W-1:0]   cfg_timeout_i,
  output logic [PD_W-1:0]   pd_o,
  output logic              phy_rst_no,
  output logic              msg_valid_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              msg_valid_i,
  input  logic [ADDR_W-1:0] msg_addr_i,
  input  logic [DATA_W-1:0] msg_data_i,
  output logic              lb_ready_o,
  output logic              norm_ready_o,
  output logic              err_o
);
  localparam int LCW = $clog2(RST_CYC + 2);

  lbk_state_e st_q, st_d;
  logic [POS_W-1:0] pos_q;
  logic err_q, to_hit;
  logic hold_run, hold_done, wait_run, expire;
  logic ack_en, ack_dis, perr;

  assign hold_run = (st_q == ST_HOLD) || (st_q == ST_EHOLD);
  assign wait_run = (st_q == ST_WAIT_EN) || (st_q == ST_WAIT_DIS);

  lbk_hold_cnt #(.N(RST_CYC)) u_hold (
    .clk_i, .rst_ni, .run_i(hold_run), .done_o(hold_done)
  );

  lbk_wait_timer #(.W(TO_W)) u_timer (
    .clk_i, .rst_ni, .run_i(wait_run), .limit_i(cfg_timeout_i), .expire_o(expire)
  );

  lbk_stat_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)) u_dec (
    .valid_i(msg_valid_i), .addr_i(msg_addr_i), .data_i(msg_data_i),
    .ack_en_o(ack_en), .ack_dis_o(ack_dis), .perr_o(perr)
  );

  always_comb begin
    st_d   = st_q;
    to_hit = 1'b0;
    unique case (st_q)
      ST_HOLD:     if (hold_done) st_d = ST_NORM;
      ST_NORM:     if (lb_req_i)  st_d = ST_EHOLD;
      ST_EHOLD:    if (hold_done) st_d = ST_SEND_EN;
      ST_SEND_EN:  st_d = ST_WAIT_EN;
      ST_WAIT_EN: begin
        if (perr)        st_d = ST_HOLD;
        else if (ack_en) st_d = ST_LOOP;
        else if (expire) begin st_d = ST_HOLD; to_hit = 1'b1; end
      end
      ST_LOOP:     if (!lb_req_i) st_d = exit_rst_i ? ST_HOLD : ST_SEND_DIS;
      ST_SEND_DIS: st_d = ST_WAIT_DIS;
      ST_WAIT_DIS: begin
        if (perr)         st_d = ST_HOLD;
        else if (ack_dis) st_d = ST_NORM;
        else if (expire)  begin st_d = ST_HOLD; to_hit = 1'b1; end
      end
      default:     st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      pos_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_NORM && lb_req_i) pos_q <= cfg_pos_i;
      else if (st_q == ST_HOLD)        pos_q <= '0;
      if (to_hit) err_q <= 1'b1;
    end
  end

  assign pd_o         = (st_q == ST_NORM || st_q == ST_LOOP) ? PD_ACTIVE : PD_OFF;
  assign phy_rst_no   = !hold_run;
  assign msg_valid_o  = (st_q == ST_SEND_EN) || (st_q == ST_SEND_DIS);
  assign msg_addr_o   = CTRL_ADDR;
  assign lb_ready_o   = (st_q == ST_LOOP);
  assign norm_ready_o = (st_q == ST_NORM);
  assign err_o        = err_q;

  always_comb begin
    msg_data_o = '0;
    msg_data_o[EN_BIT] = (st_q == ST_SEND_EN);
    msg_data_o[POS_LSB +: POS_W] = pos_q;
  end

  // checker: length of each PHY reset pulse
  logic [LCW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt_q <= '0;
    else if (!phy_rst_no) low_cnt_q <= low_cnt_q + 1'b1;
    else                  low_cnt_q <= '0;
  end

  assert_hold_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rst_no) |-> low_cnt_q == LCW'(RST_CYC));

  assert_ready_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lb_ready_o && norm_ready_o));

  assert_msg_safe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (pd_o == PD_OFF) && phy_rst_no);

  assert_lb_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lb_ready_o) |-> $past(msg_valid_i && msg_addr_i == STAT_ADDR &&
                                msg_data_i[EN_BIT] && !msg_data_i[ERR_BIT]));

  assert_norm_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(norm_ready_o) |-> $past(!phy_rst_no) ||
      $past(msg_valid_i && msg_addr_i == STAT_ADDR &&
            !msg_data_i[EN_BIT] && !msg_data_i[ERR_BIT]));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/lbk_seq_bench.sv
`timescale 1ns/1ps
module lbk_seq_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int TO_W   = 8;
  localparam int HOLD   = 16;
  localparam logic [ADDR_W-1:0] CTRL = 12'h020;
  localparam logic [ADDR_W-1:0] STAT = 12'h021;

  // vector: {pos[1:0], exit_rst, phy_err_on_exit}
  localparam logic [3:0] VEC [6] = '{4'b00_0_0, 4'b01_0_1, 4'b10_1_0,
                                     4'b11_0_0, 4'b11_0_1, 4'b01_1_0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, lb_req, exit_rst, msg_vi;
  logic [1:0] cfg_pos, pd;
  logic [TO_W-1:0] cfg_to;
  logic phy_rst_n, msg_vo, lb_rdy, nm_rdy, err;
  logic [ADDR_W-1:0] addr_o, addr_i;
  logic [DATA_W-1:0] data_o, data_i;

  lbk_seq u_lbk_seq (
    .clk_i(clk), .rst_ni(rst_n), .lb_req_i(lb_req), .exit_rst_i(exit_rst),
    .cfg_pos_i(cfg_pos), .cfg_timeout_i(cfg_to), .pd_o(pd), .phy_rst_no(phy_rst_n),
    .msg_valid_o(msg_vo), .msg_addr_o(addr_o), .msg_data_o(data_o),
    .msg_valid_i(msg_vi), .msg_addr_i(addr_i), .msg_data_i(data_i),
    .lb_ready_o(lb_rdy), .norm_ready_o(nm_rdy), .err_o(err)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic send_stat(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    msg_vi = 1'b1; addr_i = a; data_i = d;
    tick();
    msg_vi = 1'b0; addr_i = '0; data_i = '0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!phy_rst_n && n < 200) begin n++; tick(); end
  endtask

  // from NORM: request entry, check hold and control write
  task automatic enter(input logic [1:0] p, input string req);
    int n;
    lb_req = 1'b1; cfg_pos = p;
    tick();
    cfg_pos = ~p;
    chk(!phy_rst_n && pd == 2'b10, req, "entry reset/pd", {phy_rst_n, pd}, 3'b010);
    count_low(n);
    chk(n == HOLD, req, "entry hold cycles", n, HOLD);
    chk(msg_vo && addr_o == CTRL && data_o == {5'b0, p, 1'b1}, req, "enable write",
        {msg_vo, addr_o, data_o}, {1'b1, CTRL, 5'b0, p, 1'b1});
    tick();
  endtask

  initial begin
    int n;
    rst_n = 1'b0; lb_req = 0; exit_rst = 0; msg_vi = 0; cfg_pos = 0;
    cfg_to = 8'd50; addr_i = '0; data_i = '0;
    repeat (3) tick();
    // R1 reset state
    chk(!phy_rst_n && pd == 2'b10 && !lb_rdy && !nm_rdy && !msg_vo && !err, "R1",
        "reset state", {phy_rst_n, pd, lb_rdy, nm_rdy, msg_vo, err}, 7'b0100000);
    rst_n = 1'b1;
    count_low(n);
    chk(n == HOLD, "R1", "hold after reset", n, HOLD);
    chk(nm_rdy && pd == 2'b00, "R1", "normal after hold", {nm_rdy, pd}, 3'b100);

    foreach (VEC[i]) begin
      logic [1:0] p;
      bit xr, pe;
      {p, xr, pe} = VEC[i];
      enter(p, "R2");
      chk(!lb_rdy && !msg_vo, "R3", "wait before status", {lb_rdy, msg_vo}, 0);
      send_stat(12'h055, 8'h01);
      chk(!lb_rdy, "R3", "wrong address ignored", lb_rdy, 0);
      send_stat(STAT, 8'h01);
      chk(lb_rdy && !nm_rdy && pd == 2'b00, "R3", "loopback ready",
          {lb_rdy, nm_rdy, pd}, 4'b1000);
      lb_req = 1'b0; exit_rst = xr;
      tick();
      exit_rst = 1'b0;
      if (xr) begin
        chk(!phy_rst_n && !msg_vo, "R6", "direct reset exit", {phy_rst_n, msg_vo}, 0);
        count_low(n);
        chk(n == HOLD && nm_rdy, "R6", "hold then normal", {n, nm_rdy}, {HOLD, 1'b1});
      end else begin
        chk(msg_vo && addr_o == CTRL && data_o == {5'b0, p, 1'b0}, "R4", "disable write",
            {msg_vo, addr_o, data_o}, {1'b1, CTRL, 5'b0, p, 1'b0});
        tick();
        send_stat(STAT, pe ? 8'h02 : 8'h00);
        if (pe) begin
          chk(!phy_rst_n, "R5", "error reply forces reset", phy_rst_n, 0);
          count_low(n);
          chk(n == HOLD && nm_rdy, "R5", "hold then normal", {n, nm_rdy}, {HOLD, 1'b1});
        end else begin
          chk(nm_rdy && phy_rst_n && pd == 2'b00, "R4", "normal after handshake",
              {nm_rdy, phy_rst_n, pd}, 4'b1100);
        end
      end
      chk(!err, "R7", "no timeout flagged", err, 0);
    end

    // R10 entry rejected by PHY
    enter(2'b10, "R2");
    lb_req = 1'b0;
    send_stat(STAT, 8'h03);
    chk(!phy_rst_n && !lb_rdy, "R10", "entry error resets", {phy_rst_n, lb_rdy}, 0);
    count_low(n);
    chk(n == HOLD && nm_rdy && !err, "R10", "back to normal, no flag",
        {n, nm_rdy, err}, {HOLD, 2'b10});

    // R7 zero limit waits forever
    cfg_to = '0;
    enter(2'b01, "R2");
    repeat (300) tick();
    chk(phy_rst_n && !lb_rdy && !err, "R7", "zero limit no expiry",
        {phy_rst_n, lb_rdy, err}, 3'b100);
    send_stat(STAT, 8'h01);
    chk(lb_rdy, "R7", "late ack accepted", lb_rdy, 1);

    // R7 exit timeout: 4-cycle wait then reset
    cfg_to = 8'd4;
    lb_req = 1'b0;
    tick();
    chk(msg_vo && data_o[0] == 1'b0, "R4", "disable write", {msg_vo, data_o[0]}, 2'b10);
    n = 0;
    while (phy_rst_n && n < 100) begin n++; tick(); end
    chk(n == 5, "R7", "exit timeout length", n, 5);
    chk(err, "R7", "flag set on timeout", err, 1);
    count_low(n);
    chk(n == HOLD && nm_rdy && err, "R7", "reset exit, flag held",
        {n, nm_rdy, err}, {HOLD, 2'b11});

    // R7 entry timeout: 6-cycle limit
    cfg_to = 8'd6;
    enter(2'b11, "R2");
    lb_req = 1'b0;
    n = 1;
    while (phy_rst_n && n < 100) begin n++; tick(); end
    chk(n == 7, "R7", "entry timeout length", n, 7);
    count_low(n);
    chk(nm_rdy && !lb_rdy && err, "R8", "normal only, flag held",
        {nm_rdy, lb_rdy, err}, 3'b101);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule